// File: doc/BRIEF.md
# Two-Channel Burst Request Arbiter

This block lets two transfer channels share a single bus-master port. Software sets up each channel through a small word-addressed register port: an enable bit, a priority bit, a 32-bit start address and a 16-bit byte count. The channel starts when a non-zero byte count is written while the channel is already enabled.

The active channels compete for the port. A channel with the high priority bit set wins over a low-priority one. When both have the same priority, the winner alternates. The winning channel's transfer is cut into bursts. Each burst is the remaining byte count or the configured maximum burst size, whichever is smaller. Each burst is offered on a valid/ready request port, and the block then waits for a completion pulse from the bus side.

While a channel runs, its address and count registers track the values most recently handed to the port. A sticky error flag and the last-serviced channel are recorded. A self-clearing soft reset stops all channels.

Top module: `dma_dual_arb`

## Requirements
- R1: A write of a non-zero count to an enabled, inactive channel makes it active on the next cycle. A zero count, or a write to a disabled channel, starts nothing, although the count is stored. Address and count writes to an active channel are ignored.
- R2: Configuration word 8 holds the burst-size code in bits 3:0, reset value 2. Codes 2, 3, 4, 5 and 6 give 4, 8, 16, 32 and 64 bytes. Codes below 2 act as 4 bytes and codes above 6 act as 64 bytes. Each burst is the smaller of the remaining count and this maximum.
- R3: Once `mst_valid` is raised, it stays high with `mst_addr`, `mst_bytes` and `mst_chan` unchanged until `mst_ready` is seen. The block then issues no new burst until `mst_done` arrives.
- R4: At the handshake edge, the serviced channel's address grows by the burst's byte count and its remaining count shrinks by the same amount.
- R5: When both channels compete and their priority bits differ, the channel whose priority bit (ctrl bit 1) is set is served first.
- R6: When both channels compete with equal priority, the channel that was not served last wins, so grants alternate.
- R7: A channel goes inactive once its count is zero and its last burst has completed.
- R8: Clearing the enable bit (ctrl bit 0) of a running channel lets any burst already requested finish. No further burst is requested for it, and it goes inactive.
- R9: With the idle-insert bit (configuration bit 4) set, one extra cycle separates a completion from the next request. Without it, a new request follows the completion edge by two cycles.
- R10: Status word 9 shows channel 0 active in bit 0, channel 1 active in bit 1, and the sticky error in bit 17. Everything reads zero after reset.
- R11: `mst_done` together with `mst_err` aborts the serviced channel, clears its active bit and sets the sticky error. The other channel carries on.
- R12: Port-error word 11 holds the sticky error in bit 0 and, in bit 1, the channel of the most recent handshake.
- R13: Writing 1 to bit 0 of word 10 clears both active bits, the error flag and the last-channel record, and returns the sequencer to idle. This takes effect by the next cycle, and the word always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address (word index in bits 5:2; writes with bits 1:0 non-zero are ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mst_valid | output | 1 | Burst request valid |
| mst_ready | input | 1 | Bus side accepts the request |
| mst_addr | output | 32 | Burst start address |
| mst_bytes | output | 16 | Burst byte count |
| mst_chan | output | 1 | Channel owning the burst |
| mst_done | input | 1 | One-cycle pulse: the accepted burst has finished |
| mst_err | input | 1 | Qualifies `mst_done` as a failed burst |

The request port follows the usual valid/ready rule. The bus side may hold `mst_ready` low as long as it likes, and the request is simply kept. Only one burst is ever outstanding.

## Verification
Two things can fall in the same cycle: the completion of one channel's burst, and the other channel's start or its bid in arbitration. The bench stretches the completion latency so that the second channel's count write lands while the first channel's burst is still outstanding. Both channels are then waiting at the very cycle the sequencer returns to idle, and the grant order is judged against a reference model that runs every clock and against an expected channel list. Error injection and soft reset are also issued while a burst is pending, so that abort and arbitration or stall meet in one cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT, SQ_GAP} seq_st_t;

  localparam int NCH       = 2;
  localparam int CH_STRIDE = 4;   // words per channel: ctrl, addr, count
  localparam int OFS_CTRL  = 0;
  localparam int OFS_ADDR  = 1;
  localparam int OFS_CNT   = 2;
  localparam int W_CFG     = 8;
  localparam int W_STAT    = 9;
  localparam int W_SRST    = 10;
  localparam int W_PERR    = 11;
  localparam int CODE_MIN  = 2;
  localparam int CODE_MAX  = 6;
  localparam logic [3:0] CODE_RST = 4'd2;

  // burst ceiling in bytes for a size code, clamped to the legal range
  function automatic int burst_limit(logic [3:0] code);
    int c;
    c = int'(code);
    if (c < CODE_MIN) c = CODE_MIN;
    if (c > CODE_MAX) c = CODE_MAX;
    return 1 << c;
  endfunction

endpackage

// File: rtl/dma_pick.sv
module dma_pick (
  input  logic [1:0] want,
  input  logic [1:0] prio,
  input  logic       last,
  output logic       pick
);
  always_comb begin
    if (want == 2'b11) begin
      if (prio[0] != prio[1]) pick = prio[1];
      else                    pick = ~last;
    end else begin
      pick = want[1] & ~want[0];
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              grant,
  input  logic [LEN_W-1:0]  grant_bytes,
  input  logic              busy,
  input  logic              abort,
  output logic              en,
  output logic              prio,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  cnt,
  output logic              active,
  output logic              want
);
  logic [LEN_W-1:0] new_cnt;
  assign new_cnt = wdata[LEN_W-1:0];
  assign want    = active & en & (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      prio   <= 1'b0;
      addr   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en   <= wdata[0];
        prio <= wdata[1];
      end
      if (soft_clr)                                      active <= 1'b0;
      else if (abort)                                    active <= 1'b0;
      else if (active && !busy && (cnt == '0 || !en))    active <= 1'b0;
      else if (!active && wr_cnt && en && new_cnt != '0) active <= 1'b1;
      if (!active && wr_addr) addr <= wdata;
      if (!active && wr_cnt)  cnt  <= new_cnt;
      if (grant) begin
        addr <= addr + ADDR_W'(grant_bytes);
        cnt  <= cnt - grant_bytes;
      end
    end
  end

  // R4
  grant_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (cnt == $past(cnt) - $past(grant_bytes)) &&
              (addr == $past(addr) + ADDR_W'($past(grant_bytes))));
  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && wr_cnt && en && new_cnt != '0 && !soft_clr) |=> active);
  // R7
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !busy && cnt == '0) |=> !active);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_arb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_clr,
  input  logic [NCH-1:0]            want,
  input  logic                      pick,
  input  logic [NCH-1:0][LEN_W-1:0] rem,
  input  logic [LEN_W-1:0]          max_bytes,
  input  logic                      idle_en,
  input  logic                      mst_ready,
  input  logic                      mst_done,
  input  logic                      mst_err,
  output logic                      mst_valid,
  output logic [LEN_W-1:0]          mst_bytes,
  output logic                      own,
  output logic                      last_ch,
  output logic [NCH-1:0]            busy,
  output logic [NCH-1:0]            grant,
  output logic [NCH-1:0]            abort
);
  seq_st_t          st;
  logic [LEN_W-1:0] pick_rem;
  logic             hs, fail;

  assign pick_rem  = rem[pick];
  assign mst_valid = (st == SQ_REQ);
  assign hs        = (st == SQ_REQ) && mst_ready && !soft_clr;
  assign fail      = (st == SQ_WAIT) && mst_done && mst_err && !soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      own       <= 1'b0;
      mst_bytes <= '0;
      last_ch   <= 1'b0;
    end else if (soft_clr) begin
      st      <= SQ_IDLE;
      last_ch <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (|want) begin
          st        <= SQ_REQ;
          own       <= pick;
          mst_bytes <= (pick_rem < max_bytes) ? pick_rem : max_bytes;
        end
        SQ_REQ: if (mst_ready) begin
          st      <= SQ_WAIT;
          last_ch <= own;
        end
        SQ_WAIT: if (mst_done) st <= idle_en ? SQ_GAP : SQ_IDLE;
        SQ_GAP:  st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic mine;
    assign mine     = (own == 1'(i));
    assign busy[i]  = (st == SQ_REQ || st == SQ_WAIT) && mine;
    assign grant[i] = hs && mine;
    assign abort[i] = fail && mine;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_valid && !mst_ready && !soft_clr) |=>
      (mst_valid && $stable(mst_bytes) && $stable(own)));
  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT && !mst_done) |=> !mst_valid);
  // R9
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_en && st == SQ_WAIT && mst_done && !soft_clr) |=> !mst_valid ##1 !mst_valid);
endmodule

// File: rtl/dma_dual_arb.sv
module dma_dual_arb
  import dma_arb_pkg::*;
#(
  parameter int REG_AW = 6,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mst_valid,
  input  logic              mst_ready,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [LEN_W-1:0]  mst_bytes,
  output logic              mst_chan,
  input  logic              mst_done,
  input  logic              mst_err
);
  localparam int WORD_W = REG_AW - 2;

  logic [WORD_W-1:0]              word;
  logic                           wr_ok, soft_clr;
  logic [3:0]                     cfg_code;
  logic                           cfg_idle, port_err;
  logic [LEN_W-1:0]               max_bytes;
  logic [NCH-1:0]                 en, prio, active, want, busy, grant, abort;
  logic [NCH-1:0][ADDR_W-1:0]     ch_addr;
  logic [NCH-1:0][LEN_W-1:0]      ch_cnt;
  logic                           pick, own, last_ch;

  assign word      = reg_addr[REG_AW-1:2];
  assign wr_ok     = reg_wr && (reg_addr[1:0] == 2'b00);
  assign soft_clr  = wr_ok && (word == WORD_W'(W_SRST)) && reg_wdata[0];
  assign max_bytes = LEN_W'(burst_limit(cfg_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_code <= CODE_RST;
      cfg_idle <= 1'b0;
    end else if (wr_ok && word == WORD_W'(W_CFG)) begin
      cfg_code <= reg_wdata[3:0];
      cfg_idle <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        port_err <= 1'b0;
    else if (soft_clr) port_err <= 1'b0;
    else if (|abort)   port_err <= 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam int BASE = i * CH_STRIDE;
    dma_chan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (soft_clr),
      .wr_ctrl    (wr_ok && word == WORD_W'(BASE + OFS_CTRL)),
      .wr_addr    (wr_ok && word == WORD_W'(BASE + OFS_ADDR)),
      .wr_cnt     (wr_ok && word == WORD_W'(BASE + OFS_CNT)),
      .wdata      (reg_wdata[ADDR_W-1:0]),
      .grant      (grant[i]),
      .grant_bytes(mst_bytes),
      .busy       (busy[i]),
      .abort      (abort[i]),
      .en         (en[i]),
      .prio       (prio[i]),
      .addr       (ch_addr[i]),
      .cnt        (ch_cnt[i]),
      .active     (active[i]),
      .want       (want[i])
    );
  end

  dma_pick u_pick (
    .want(want),
    .prio(prio),
    .last(last_ch),
    .pick(pick)
  );

  dma_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .want     (want),
    .pick     (pick),
    .rem      (ch_cnt),
    .max_bytes(max_bytes),
    .idle_en  (cfg_idle),
    .mst_ready(mst_ready),
    .mst_done (mst_done),
    .mst_err  (mst_err),
    .mst_valid(mst_valid),
    .mst_bytes(mst_bytes),
    .own      (own),
    .last_ch  (last_ch),
    .busy     (busy),
    .grant    (grant),
    .abort    (abort)
  );

  assign mst_addr = ch_addr[own];
  assign mst_chan = own;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (word == WORD_W'(i * CH_STRIDE + OFS_CTRL)) reg_rdata = {30'b0, prio[i], en[i]};
      if (word == WORD_W'(i * CH_STRIDE + OFS_ADDR)) reg_rdata = 32'(ch_addr[i]);
      if (word == WORD_W'(i * CH_STRIDE + OFS_CNT))  reg_rdata = 32'(ch_cnt[i]);
    end
    if (word == WORD_W'(W_CFG))  reg_rdata = {27'b0, cfg_idle, cfg_code};
    if (word == WORD_W'(W_STAT)) reg_rdata = {14'b0, port_err, 15'b0, active};
    if (word == WORD_W'(W_PERR)) reg_rdata = {30'b0, last_ch, port_err};
  end

  // R2
  burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> (mst_bytes != '0) && (mst_bytes <= max_bytes));
  // R5
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mst_valid) && $past(want == 2'b11) && $past(prio[0] != prio[1]))
      |-> (mst_chan == $past(prio[1])));
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort) |=> port_err && ((active & $past(abort)) == '0));
  // R13
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (active == '0) && !port_err && !mst_valid);
endmodule

// File: tb/tb_dma_dual_arb.sv
`timescale 1ns/1ps
module tb_dma_dual_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mst_valid, mst_chan;
  logic        mst_ready = 1'b0, mst_done = 1'b0, mst_err = 1'b0;
  logic [31:0] mst_addr;
  logic [15:0] mst_bytes;

  always #2 clk = ~clk;

  dma_dual_arb dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_valid(mst_valid),
    .mst_ready(mst_ready), .mst_addr(mst_addr), .mst_bytes(mst_bytes),
    .mst_chan(mst_chan), .mst_done(mst_done), .mst_err(mst_err)
  );

  int nchk = 0, nerr = 0;
  bit ended = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bus-side stub ----------------
  bit stall = 0, inj_err = 0, pend = 0, prev_v = 0;
  int done_lat = 1, dcnt = 0, cyc = 0, t_done = -1;
  int glog[$], blog[$], gaps[$];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mst_ready = 0; mst_done = 0; mst_err = 0; pend = 0; prev_v = 0;
    end else begin
      mst_done = 0; mst_err = 0;
      if (pend) begin
        if (dcnt == 0) begin
          mst_done = 1; mst_err = inj_err; inj_err = 0; pend = 0; t_done = cyc;
        end else dcnt--;
      end
      if (mst_valid && !prev_v && t_done >= 0) gaps.push_back(cyc - t_done);
      prev_v = mst_valid;
      if (mst_ready) begin
        mst_ready = 0;
        glog.push_back(int'(mst_chan));
        blog.push_back(int'(mst_bytes));
        dcnt = done_lat; pend = 1;
      end else if (mst_valid && !stall && !pend) mst_ready = 1;
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_st, m_own, m_last, m_bytes, m_code;
  bit m_err, m_idle;
  bit m_en[2], m_pr[2], m_act[2];
  logic [31:0] m_addr[2];
  int m_len[2];

  function automatic int lim(int c);
    if (c < 2) c = 2;
    if (c > 6) c = 6;
    return 1 << c;
  endfunction

  always @(posedge clk) begin
    int st, o, wi, pk;
    bit hs, dn, er, sft, bz;
    bit want[2], act_o[2], en_o[2];
    int len_o[2];
    if (!rst_n) begin
      m_st = 0; m_own = 0; m_last = 0; m_bytes = 0; m_code = 2; m_err = 0; m_idle = 0;
      for (int i = 0; i < 2; i++) begin
        m_en[i] = 0; m_pr[i] = 0; m_act[i] = 0; m_addr[i] = 0; m_len[i] = 0;
      end
    end else begin
      st = m_st; o = m_own;
      wi = reg_wr ? int'(reg_addr[5:2]) : -1;
      hs = (st == 1) && mst_ready;
      dn = (st == 2) && mst_done;
      er = dn && mst_err;
      sft = (wi == 10) && reg_wdata[0];
      for (int i = 0; i < 2; i++) begin
        act_o[i] = m_act[i]; en_o[i] = m_en[i]; len_o[i] = m_len[i];
        want[i] = m_act[i] && m_en[i] && (m_len[i] != 0);
      end
      if (want[0] && want[1]) pk = (m_pr[0] != m_pr[1]) ? int'(m_pr[1]) : (m_last == 0 ? 1 : 0);
      else pk = want[1] ? 1 : 0;
      if (sft) begin
        m_act[0] = 0; m_act[1] = 0; m_err = 0; m_last = 0; m_st = 0;
      end else begin
        for (int i = 0; i < 2; i++) begin
          bz = (st == 1 || st == 2) && (o == i);
          if (er && o == i) m_act[i] = 0;
          else if (act_o[i] && !bz && (len_o[i] == 0 || !en_o[i])) m_act[i] = 0;
          else if (!act_o[i] && wi == i*4+2 && en_o[i] && reg_wdata[15:0] != 0) m_act[i] = 1;
          if (wi == i*4) begin m_en[i] = reg_wdata[0]; m_pr[i] = reg_wdata[1]; end
          if (!act_o[i] && wi == i*4+1) m_addr[i] = reg_wdata;
          if (!act_o[i] && wi == i*4+2) m_len[i] = int'(reg_wdata[15:0]);
          if (hs && o == i) begin m_addr[i] = m_addr[i] + 32'(m_bytes); m_len[i] -= m_bytes; end
        end
        if (er) m_err = 1;
        if (hs) m_last = o;
        case (st)
          0: if (want[0] || want[1]) begin
               m_st = 1; m_own = pk;
               m_bytes = (len_o[pk] < lim(m_code)) ? len_o[pk] : lim(m_code);
             end
          1: if (hs) m_st = 2;
          2: if (dn) m_st = m_idle ? 3 : 0;
          default: m_st = 0;
        endcase
      end
      if (wi == 8) begin m_code = int'(reg_wdata[3:0]); m_idle = reg_wdata[4]; end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(mst_valid == (m_st == 1), "R3 valid vs model", mst_valid, m_st == 1);
      if (mst_valid && m_st == 1) begin
        chk(mst_chan == 1'(m_own), "R5/R6 channel vs model", mst_chan, m_own);
        chk(mst_bytes == 16'(m_bytes), "R2 bytes vs model", mst_bytes, m_bytes);
        chk(mst_addr == m_addr[m_own], "R4 address vs model", mst_addr, m_addr[m_own]);
      end
    end
  end

  // ---------------- register tasks ----------------
  task automatic wr(int w, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 6'(w * 4); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int w, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = 6'(w * 4); #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); reg_addr = 6'(9 * 4); #1;
      if (reg_rdata[1:0] == 2'b00 && !mst_valid && !pend) return;
    end
    chk(0, "wait_idle timeout", 0, 1);
  endtask

  task automatic expect_list(string tag, int got[$], int exp[$]);
    chk(got.size() == exp.size(), tag, got.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got.size(); k++) chk(got[k] == exp[k], tag, got[k], exp[k]);
  endtask

  task automatic clr_logs();
    glog.delete(); blog.delete(); gaps.delete(); t_done = -1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(9, 32'h0, "R10 status after reset");
    rd(8, 32'h2, "R2 burst code reset value");
    rd(11, 32'h0, "R12 port-error word after reset");

    // R4 / R7: basic split with 4-byte bursts
    clr_logs();
    wr(0, 32'h1); wr(1, 32'h1000); wr(2, 10);
    wait_idle();
    rd(1, 32'h100A, "R4 address advanced");
    rd(2, 32'h0, "R7 count drained");
    expect_list("R2 burst list 4/4/2", blog, '{4, 4, 2});

    // R1: no start on zero count or disabled channel
    wr(2, 0);
    rd(9, 32'h0, "R1 zero count does not start");
    wr(4, 32'h0); wr(6, 8);
    rd(9, 32'h0, "R1 disabled channel does not start");
    rd(6, 32'h8, "R1 count stored on disabled channel");

    // R1: writes ignored while active
    stall = 1;
    wr(2, 8);
    rd(9, 32'h1, "R1 enabled start");
    wr(1, 32'h5555); wr(2, 3);
    rd(1, 32'h100A, "R1 address write ignored while active");
    rd(2, 32'h8, "R1 count write ignored while active");
    stall = 0;
    wait_idle();
    rd(1, 32'h1012, "R4 address after resumed transfer");

    // R2: other size codes
    clr_logs(); wr(8, 4); wr(2, 40); wait_idle();
    expect_list("R2 code 4 bursts", blog, '{16, 16, 8});
    clr_logs(); wr(8, 7); wr(2, 100); wait_idle();
    expect_list("R2 code 7 clamps to 64", blog, '{64, 36});
    clr_logs(); wr(8, 0); wr(2, 6); wait_idle();
    expect_list("R2 code 0 clamps to 4", blog, '{4, 2});

    // R5: high priority wins while the other channel's burst is outstanding
    wr(8, 2); done_lat = 8; clr_logs();
    wr(0, 32'h1); wr(4, 32'h3); wr(5, 32'h3000);
    wr(2, 8);
    while (glog.size() < 1) @(negedge clk);
    wr(6, 8);
    wait_idle();
    expect_list("R5 priority grant order", glog, '{0, 1, 1, 0});

    // R6: equal priority alternates
    clr_logs(); wr(4, 32'h1);
    wr(2, 12);
    while (glog.size() < 1) @(negedge clk);
    wr(6, 12);
    wait_idle();
    expect_list("R6 round-robin grant order", glog, '{0, 1, 0, 1, 0, 1});

    // R8: disable mid-transfer
    clr_logs(); done_lat = 6;
    wr(1, 32'h4000); wr(2, 40);
    while (glog.size() < 1) @(negedge clk);
    wr(0, 32'h0);
    wait_idle();
    chk(glog.size() == 1, "R8 only current burst completes", glog.size(), 1);
    rd(2, 32'd36, "R8 remaining count after disable");
    rd(1, 32'h4004, "R8 address after disable");
    rd(9, 32'h0, "R8 channel inactive");

    // R9: idle insertion
    done_lat = 1; wr(0, 32'h1);
    clr_logs(); wr(2, 8); wait_idle();
    chk(gaps.size() == 1 && gaps[0] == 2, "R9 gap without idle insert", gaps.size() ? gaps[0] : -1, 2);
    wr(8, 32'h12); rd(8, 32'h12, "R9 idle bit readback");
    clr_logs(); wr(2, 8); wait_idle();
    chk(gaps.size() == 1 && gaps[0] == 3, "R9 gap with idle insert", gaps.size() ? gaps[0] : -1, 3);
    wr(8, 2);

    // R11 / R12: error aborts channel 0, channel 1 completes
    clr_logs(); wr(4, 32'h1);
    inj_err = 1; stall = 1;
    wr(2, 8); wr(6, 8);
    stall = 0;
    wait_idle();
    expect_list("R11 grants after abort", glog, '{0, 1, 1});
    rd(9, 32'h0002_0000, "R11 sticky error in status bit 17");
    rd(11, 32'h3, "R12 last channel and error bit");
    rd(2, 32'h4, "R11 aborted channel count frozen");

    // R13: soft reset during a stalled request
    stall = 1;
    wr(2, 8);
    rd(9, 32'h0002_0001, "R13 precondition active");
    wr(10, 32'h1);
    rd(9, 32'h0, "R13 actives and error cleared");
    chk(mst_valid == 0, "R13 request withdrawn", mst_valid, 0);
    rd(10, 32'h0, "R13 reset word reads zero");
    rd(11, 32'h0, "R13 port-error word cleared");
    stall = 0; clr_logs();
    wr(2, 4); wait_idle();
    expect_list("R13 channel usable after soft reset", glog, '{0});

    ended = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule